// File: doc/BRIEF.md
# Execute Packet Splitter

This block sits between instruction fetch and decode in a wide-issue processor. It accepts a fetch packet of eight 32-bit instructions and issues it downstream as a run of execute packets, one per cycle. Each execute packet is a group of instructions that decode must take together in a single cycle.

The low bit of every instruction is a chaining flag. When it is set, the instruction that follows in program order joins the same group. When it is clear, the next instruction opens a new group. One fetch packet can therefore take anywhere from one issue cycle (all eight chained) to eight issue cycles (nothing chained).

Both sides use valid/ready handshakes. The block keeps the fetch packet until the last group drawn from it is accepted. In that same cycle it can take the next fetch packet, so the output has no bubble between packets.

Top module: `ep_splitter`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it is released with no fetch input, `ep_valid_o` is 0 and `fp_ready_o` is 1.
- R2: Slot 0 (`fp_data_i[31:0]`) is first in program order and slot 7 (`fp_data_i[255:224]`) is last. A group starts at the current slot and extends while bit 0 of its latest slot is 1. It ends at the first slot whose bit 0 is 0.
- R3: Instructions of a group appear on lanes packed from lane 0 in program order. Lane k occupies `ep_data_o[32k+31:32k]`. `ep_lane_vld_o` has exactly its low `ep_count_o` bits set, and lanes that are not valid carry zero.
- R4: `ep_count_o` equals the number of instructions in the current group (1 to 8) while `ep_valid_o` is 1.
- R5: Slot 7 always ends its group, even when its bit 0 is 1. No group crosses a fetch packet boundary.
- R6: While `ep_valid_o` is 1 and `ep_ready_i` is 0, the block holds `ep_valid_o`, `ep_data_o` and `ep_count_o` unchanged into the next cycle.
- R7: `fp_ready_o` is 1 exactly when no fetch packet is held, or when the group being accepted in this cycle is the last one of the held packet. A packet accepted in that cycle issues its first group in the next cycle.
- R8: A packet with bit 0 set in every slot issues as one group of 8. A packet with bit 0 clear in every slot issues as eight groups of 1.
- R9: With chaining bits 1,0,1,1,0,1,1,0 for slots 0..7, the block issues groups of 2, 3 and 3 instructions in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_valid_i | input | 1 | Fetch packet valid |
| fp_ready_o | output | 1 | Block can take a fetch packet |
| fp_data_i | input | 256 | Fetch packet, slot 0 in bits 31:0 |
| ep_valid_o | output | 1 | Execute packet valid |
| ep_ready_i | input | 1 | Decode accepts the execute packet |
| ep_data_o | output | 256 | Packed lanes, lane 0 in bits 31:0 |
| ep_lane_vld_o | output | 8 | Per-lane valid flags |
| ep_count_o | output | 4 | Instructions in the execute packet |

## Verification
Two events can fall in the same cycle: decode accepts the final group of the held packet, and fetch hands over the next packet. The bench keeps fetch valid asserted while groups drain and toggles decode ready at random, so this overlap occurs often, and it also occurs while the output is stalled. In every cycle, the expected `fp_ready_o` and `ep_valid_o` come from a bench model of the groups still pending. The model checks that the new packet is taken only on the final acceptance, and that its first group appears in the very next cycle.

// File: rtl/ep_pkg.sv
package ep_pkg;
  localparam int INSTR_W_D = 32;
  localparam int SLOTS_D   = 8;

  typedef enum logic {
    ST_EMPTY = 1'b0,
    ST_FULL  = 1'b1
  } buf_st_e;
endpackage

// File: rtl/ep_boundary.sv
// Finds the slot that closes the group starting at ptr_i.
module ep_boundary #(
  parameter int SLOTS = 8,
  localparam int PTR_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] par_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] end_o,
  output logic             last_o
);
  always_comb begin
    end_o = PTR_W'(SLOTS - 1);
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if ((!par_i[j] || j == SLOTS - 1) && PTR_W'(j) >= ptr_i)
        end_o = PTR_W'(j);
    end
  end

  assign last_o = (end_o == PTR_W'(SLOTS - 1));
endmodule

// File: rtl/ep_lane_pack.sv
// Packs slots ptr_i .. ptr_i+cnt_i-1 onto lanes 0.. in program order.
module ep_lane_pack #(
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 8,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int CNT_W  = PTR_W + 1,
  localparam int FP_W   = INSTR_W * SLOTS
) (
  input  logic [FP_W-1:0]  fp_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [FP_W-1:0]  data_o,
  output logic [SLOTS-1:0] lane_vld_o
);
  logic [INSTR_W-1:0] slot [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot[s] = fp_i[s*INSTR_W +: INSTR_W];
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_lane
    logic [PTR_W-1:0] src;
    assign src           = ptr_i + PTR_W'(k);
    assign lane_vld_o[k] = cnt_i > CNT_W'(k);
    assign data_o[k*INSTR_W +: INSTR_W] = lane_vld_o[k] ? slot[src] : '0;
  end
endmodule

// File: rtl/ep_splitter.sv
module ep_splitter
  import ep_pkg::*;
#(
  parameter int INSTR_W = INSTR_W_D,
  parameter int SLOTS   = SLOTS_D,
  localparam int PTR_W  = $clog2(SLOTS),
  localparam int CNT_W  = PTR_W + 1,
  localparam int FP_W   = INSTR_W * SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_valid_i,
  output logic             fp_ready_o,
  input  logic [FP_W-1:0]  fp_data_i,
  output logic             ep_valid_o,
  input  logic             ep_ready_i,
  output logic [FP_W-1:0]  ep_data_o,
  output logic [SLOTS-1:0] ep_lane_vld_o,
  output logic [CNT_W-1:0] ep_count_o
);
  buf_st_e          st_q;
  logic [FP_W-1:0]  fp_q;
  logic [PTR_W-1:0] ptr_q;

  logic [SLOTS-1:0] par;
  logic [PTR_W-1:0] end_s;
  logic             last_s;
  logic [CNT_W-1:0] cnt_raw;
  logic [CNT_W-1:0] cnt;
  logic             ep_fire;
  logic             fp_fire;

  for (genvar g = 0; g < SLOTS; g++) begin : g_par
    assign par[g] = fp_q[g*INSTR_W];
  end

  ep_boundary #(.SLOTS(SLOTS)) u_bnd (
    .par_i  (par),
    .ptr_i  (ptr_q),
    .end_o  (end_s),
    .last_o (last_s)
  );

  assign cnt_raw = CNT_W'(end_s) - CNT_W'(ptr_q) + CNT_W'(1);
  assign cnt     = ep_valid_o ? cnt_raw : '0;

  ep_lane_pack #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) u_pack (
    .fp_i       (fp_q),
    .ptr_i      (ptr_q),
    .cnt_i      (cnt),
    .data_o     (ep_data_o),
    .lane_vld_o (ep_lane_vld_o)
  );

  assign ep_valid_o = (st_q == ST_FULL);
  assign ep_count_o = cnt;
  assign ep_fire    = ep_valid_o & ep_ready_i;
  // take the next packet in the cycle the final group leaves
  assign fp_ready_o = (st_q == ST_EMPTY) | (ep_fire & last_s);
  assign fp_fire    = fp_valid_i & fp_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_EMPTY;
      fp_q  <= '0;
      ptr_q <= '0;
    end else if (fp_fire) begin
      st_q  <= ST_FULL;
      fp_q  <= fp_data_i;
      ptr_q <= '0;
    end else if (ep_fire) begin
      if (last_s) begin
        st_q  <= ST_EMPTY;
        ptr_q <= '0;
      end else begin
        ptr_q <= end_s + PTR_W'(1);
      end
    end
  end
endmodule

// File: rtl/ep_splitter_chk.sv
module ep_splitter_chk #(
  parameter int INSTR_W = 32,
  parameter int SLOTS   = 8,
  localparam int CNT_W  = $clog2(SLOTS) + 1,
  localparam int FP_W   = INSTR_W * SLOTS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fp_ready_o,
  input logic             ep_valid_o,
  input logic             ep_ready_i,
  input logic [FP_W-1:0]  ep_data_o,
  input logic [SLOTS-1:0] ep_lane_vld_o,
  input logic [CNT_W-1:0] ep_count_o
);
  assert_empty_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ep_valid_o |-> fp_ready_o);

  assert_stall_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o && !ep_ready_i |-> !fp_ready_o);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o && !ep_ready_i |=> ep_valid_o && $stable(ep_data_o) && $stable(ep_count_o));

  assert_count_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o |-> ep_count_o >= CNT_W'(1) && ep_count_o <= CNT_W'(SLOTS));

  assert_lane_pack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o |-> ep_lane_vld_o[0] && $countones(ep_lane_vld_o) == int'(ep_count_o));

  assert_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_valid_o && ep_count_o > CNT_W'(1) |-> ep_data_o[0]);
endmodule

bind ep_splitter ep_splitter_chk #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fp_ready_o    (fp_ready_o),
  .ep_valid_o    (ep_valid_o),
  .ep_ready_i    (ep_ready_i),
  .ep_data_o     (ep_data_o),
  .ep_lane_vld_o (ep_lane_vld_o),
  .ep_count_o    (ep_count_o)
);

// File: tb/ep_splitter_tb.sv
`timescale 1ns/1ps
module ep_splitter_tb;
  localparam int W = 32;
  localparam int S = 8;
  localparam int FPW = W * S;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           fp_valid_i = 1'b0;
  logic           fp_ready_o;
  logic [FPW-1:0] fp_data_i = '0;
  logic           ep_valid_o;
  logic           ep_ready_i = 1'b0;
  logic [FPW-1:0] ep_data_o;
  logic [S-1:0]   ep_lane_vld_o;
  logic [3:0]     ep_count_o;

  always #4 clk_i = ~clk_i;

  ep_splitter u_dut (
    .clk_i, .rst_ni, .fp_valid_i, .fp_ready_o, .fp_data_i,
    .ep_valid_o, .ep_ready_i, .ep_data_o, .ep_lane_vld_o, .ep_count_o
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit timed_out = 0;

  logic [FPW-1:0] fps[$];
  logic [FPW-1:0] exp_d[$];
  logic [3:0]     exp_c[$];
  int             seen_c[$];

  task automatic chk(string tag, logic [FPW-1:0] act, logic [FPW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FPW-1:0] make_fp(logic [S-1:0] pbits);
    logic [FPW-1:0] f;
    for (int i = 0; i < S; i++) begin
      logic [W-1:0] w;
      w = $urandom;
      w[0] = pbits[i];
      f[i*W +: W] = w;
    end
    return f;
  endfunction

  task automatic split_push(logic [FPW-1:0] f);
    int p = 0;
    while (p < S) begin
      int e = p;
      logic [FPW-1:0] d = '0;
      while (e < S - 1 && f[e*W] == 1'b1) e++;
      for (int k = 0; k <= e - p; k++) d[k*W +: W] = f[(p+k)*W +: W];
      exp_d.push_back(d);
      exp_c.push_back(4'(e - p + 1));
      p = e + 1;
    end
  endtask

  task automatic run(string tag, int vpct, int rpct);
    int  idx = 0;
    bit  acc = 0;
    while ((idx < fps.size() || exp_d.size() > 0 || fp_valid_i) && !timed_out) begin
      int rem;
      bit exp_rdy;
      @(negedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        timed_out = 1;
        failures++;
        $display("FAIL watchdog %s actual=hung expected=done", tag);
        break;
      end
      if (acc) fp_valid_i = 1'b0;
      if (!fp_valid_i && idx < fps.size() && int'($urandom % 100) < vpct) begin
        fp_valid_i = 1'b1;
        fp_data_i  = fps[idx];
      end
      ep_ready_i = int'($urandom % 100) < rpct;
      #2;
      rem = exp_d.size();
      exp_rdy = (rem == 0) || (rem == 1 && ep_ready_i);
      chk({tag, " R7 fp_ready"}, FPW'(fp_ready_o), FPW'(exp_rdy));
      chk({tag, " R7 ep_valid"}, FPW'(ep_valid_o), FPW'(rem > 0));
      if (rem > 0 && ep_valid_o) begin
        chk({tag, " R4 count"}, FPW'(ep_count_o), FPW'(exp_c[0]));
        chk({tag, " R3 lanes"}, FPW'(ep_lane_vld_o), FPW'((9'd1 << exp_c[0]) - 9'd1));
        chk({tag, " R2 data"}, ep_data_o, exp_d[0]);
        if (ep_ready_i) begin
          seen_c.push_back(int'(ep_count_o));
          void'(exp_d.pop_front());
          void'(exp_c.pop_front());
        end
      end
      acc = fp_valid_i && fp_ready_o;
      if (acc) begin
        split_push(fp_data_i);
        idx++;
      end
    end
    fps.delete();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", FPW'(ep_valid_o), '0);
    chk("R1 reset ready", FPW'(fp_ready_o), FPW'(1));
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle valid", FPW'(ep_valid_o), '0);
    chk("R1 idle ready", FPW'(fp_ready_o), FPW'(1));

    // R9 example pattern, slot i chaining bit in pbits[i]
    seen_c.delete();
    fps.push_back(make_fp(8'h6D));
    run("R9", 100, 100);
    chk("R9 group count", FPW'(seen_c.size()), FPW'(3));
    if (seen_c.size() == 3) begin
      chk("R9 group0", FPW'(seen_c[0]), FPW'(2));
      chk("R9 group1", FPW'(seen_c[1]), FPW'(3));
      chk("R9 group2", FPW'(seen_c[2]), FPW'(3));
    end

    // R8 all chained, then none chained
    seen_c.delete();
    fps.push_back(make_fp(8'hFF));
    fps.push_back(make_fp(8'h00));
    run("R8", 100, 100);
    chk("R8 groups", FPW'(seen_c.size()), FPW'(9));
    if (seen_c.size() == 9) chk("R8 full group", FPW'(seen_c[0]), FPW'(8));

    // R5 slot 7 chained but must close its group
    fps.push_back(make_fp(8'h80));
    fps.push_back(make_fp(8'hC0));
    fps.push_back(make_fp(8'hFE));
    run("R5", 100, 100);

    // R6 heavy stall with back-to-back fetch
    for (int i = 0; i < 40; i++) fps.push_back(make_fp(8'($urandom)));
    run("R6", 100, 25);

    // R2 random mix
    for (int i = 0; i < 400; i++) fps.push_back(make_fp(8'($urandom)));
    run("R2", 70, 70);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule